// File: doc/BRIEF.md
# Fractional Fixed-Point Multiplier with Optional Saturation

This block multiplies two signed fractional operands and returns the doubled product, so that the binary point of the result lines up with the binary point of the operands. It runs either in a narrow mode, taking 16-bit Q15 operands from the low half of each operand port, or in a wide mode, taking full 32-bit Q31 operands. The product is formed at double width in two's complement, then shifted left by one bit. The most significant product bit, which only repeats the sign, is dropped.

Two arithmetic variants are offered in each mode. The wraparound variant always returns the shifted product. It raises its flag when the two top bits of the unshifted product are both one. The clamping variant checks for the single operand pair whose doubled product cannot be represented: both operands at the most negative value. For that pair it returns the largest positive value and sets the flag. For every other pair it behaves exactly like the wraparound variant. Operands and mode bits are taken on a cycle where the input strobe is high. Result, flag and output strobe appear on the next clock edge and are held until the next accepted operation.

Top module: `frac_mul`

## Requirements
- R1: In narrow mode (`wide_mode`=0) with `sat_mode`=0, `result[31:0]` equals the 32-bit two's complement product of `op_a[15:0]` and `op_b[15:0]` shifted left by one, and `result[63:32]` is zero.
- R2: In wide mode (`wide_mode`=1) with `sat_mode`=0, `result` equals the 64-bit two's complement product of `op_a` and `op_b` shifted left by one.
- R3: When the clamp does not apply, `sat_flag` is 1 exactly when the two most significant bits of the unshifted double-width product are both 1. This gives bits 31:30 in narrow mode and bits 63:62 in wide mode.
- R4: In narrow mode with `sat_mode`=1 and both `op_a[15:0]` and `op_b[15:0]` equal to 0x8000, `result` is 0x000000007FFFFFFF and `sat_flag` is 1.
- R5: In wide mode with `sat_mode`=1 and both operands equal to 0x80000000, `result` is 0x7FFFFFFFFFFFFFFF and `sat_flag` is 1.
- R6: With `sat_mode`=1 and any other operand pair, result and flag are identical to those for `sat_mode`=0. This includes a single most-negative operand.
- R7: In narrow mode, `op_a[31:16]` and `op_b[31:16]` have no effect on result or flag.
- R8: `out_valid` is 1 in exactly the cycle after each cycle where `in_valid` is 1, and 0 otherwise.
- R9: When `in_valid` is 0, `result` and `sat_flag` keep their previous values.
- R10: A synchronous active-high `rst` clears `result`, `sat_flag` and `out_valid` to zero on the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand strobe; operands and modes are taken when high |
| wide_mode | input | 1 | 1: 32-bit Q31 operands; 0: 16-bit Q15 operands in the low half |
| sat_mode | input | 1 | 1: clamp the most-negative squared case; 0: wraparound |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| out_valid | output | 1 | High one cycle after an accepted operation |
| result | output | 64 | Doubled product; narrow results are zero-extended |
| sat_flag | output | 1 | Clamp or top-two-bits flag |

## Verification
The assertions assume that `rst` is driven to a known level from the first edge. They also assume that `in_valid`, `wide_mode`, `sat_mode` and the operands are stable and free of X around each rising edge. The bench changes all inputs only on falling edges and holds reset for several cycles at start-up. The clamp assertions apply only to the exact most-negative pair in each mode. Every other case is compared against a model computed from the requirements in the bench. The stimulus includes single most-negative operands, negative-times-positive products that set the flag, junk in the unused upper operand halves, and back-to-back strobes.

// File: rtl/frac_mul_pkg.sv
package frac_mul_pkg;
  localparam int unsigned FULL_W = 32;
  localparam int unsigned HALF_W = FULL_W / 2;
  localparam int unsigned RES_W  = 2 * FULL_W;

  typedef struct packed {
    logic [RES_W-1:0] value;
    logic             flag;
  } frac_res_t;
endpackage

// File: rtl/frac_lane.sv
module frac_lane #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  logic           clamp_en,
  output logic [2*W-1:0] prod_dbl,
  output logic           flag
);
  localparam int unsigned PW = 2 * W;
  localparam logic [W-1:0]  MOST_NEG = {1'b1, {(W-1){1'b0}}};
  localparam logic [PW-1:0] POS_MAX  = {1'b0, {(PW-1){1'b1}}};

  logic signed [PW-1:0] a_ext;
  logic signed [PW-1:0] b_ext;
  logic signed [PW-1:0] raw;
  logic                 both_min;

  assign a_ext    = {{W{a[W-1]}}, a};
  assign b_ext    = {{W{b[W-1]}}, b};
  assign raw      = a_ext * b_ext;
  assign both_min = (a == MOST_NEG) && (b == MOST_NEG);

  always_comb begin
    if (clamp_en && both_min) begin
      prod_dbl = POS_MAX;
      flag     = 1'b1;
    end else begin
      prod_dbl = {raw[PW-2:0], 1'b0};
      flag     = raw[PW-1] & raw[PW-2];
    end
  end
endmodule

// File: rtl/frac_out_reg.sv
module frac_out_reg
  import frac_mul_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      load,
  input  frac_res_t d,
  output frac_res_t q,
  output logic      q_valid
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q       <= '0;
      q_valid <= 1'b0;
    end else begin
      q_valid <= load;
      if (load) q <= d;
    end
  end
endmodule

// File: rtl/frac_mul.sv
module frac_mul
  import frac_mul_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             wide_mode,
  input  logic             sat_mode,
  input  logic [FULL_W-1:0] op_a,
  input  logic [FULL_W-1:0] op_b,
  output logic             out_valid,
  output logic [RES_W-1:0] result,
  output logic             sat_flag
);
  logic [2*HALF_W-1:0] narrow_val;
  logic                narrow_flag;
  logic [2*FULL_W-1:0] wide_val;
  logic                wide_flag;
  frac_res_t           next_res;
  frac_res_t           held_res;

  frac_lane #(.W(HALF_W)) u_narrow (
    .a        (op_a[HALF_W-1:0]),
    .b        (op_b[HALF_W-1:0]),
    .clamp_en (sat_mode),
    .prod_dbl (narrow_val),
    .flag     (narrow_flag)
  );

  frac_lane #(.W(FULL_W)) u_wide (
    .a        (op_a),
    .b        (op_b),
    .clamp_en (sat_mode),
    .prod_dbl (wide_val),
    .flag     (wide_flag)
  );

  always_comb begin
    if (wide_mode) begin
      next_res.value = wide_val;
      next_res.flag  = wide_flag;
    end else begin
      next_res.value = {{(RES_W-2*HALF_W){1'b0}}, narrow_val};
      next_res.flag  = narrow_flag;
    end
  end

  frac_out_reg u_out (
    .clk     (clk),
    .rst     (rst),
    .load    (in_valid),
    .d       (next_res),
    .q       (held_res),
    .q_valid (out_valid)
  );

  assign result   = held_res.value;
  assign sat_flag = held_res.flag;
endmodule

// File: rtl/frac_mul_chk.sv
module frac_mul_chk
  import frac_mul_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              wide_mode,
  input logic              sat_mode,
  input logic [FULL_W-1:0] op_a,
  input logic [FULL_W-1:0] op_b,
  input logic              out_valid,
  input logic [RES_W-1:0]  result,
  input logic              sat_flag
);
  localparam logic [HALF_W-1:0] H_MIN = {1'b1, {(HALF_W-1){1'b0}}};
  localparam logic [FULL_W-1:0] F_MIN = {1'b1, {(FULL_W-1){1'b0}}};

  // R8
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R8
  valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(result) && $stable(sat_flag)));

  // R4
  narrow_clamp_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !wide_mode && sat_mode &&
     op_a[HALF_W-1:0] == H_MIN && op_b[HALF_W-1:0] == H_MIN)
    |=> (result == 64'h0000_0000_7FFF_FFFF && sat_flag));

  // R5
  wide_clamp_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && wide_mode && sat_mode && op_a == F_MIN && op_b == F_MIN)
    |=> (result == 64'h7FFF_FFFF_FFFF_FFFF && sat_flag));

  // R1
  narrow_upper_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !wide_mode) |=> (result[RES_W-1:RES_W/2] == '0));

  // R10
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!out_valid && result == '0 && !sat_flag));
endmodule

bind frac_mul frac_mul_chk u_frac_mul_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .wide_mode (wide_mode),
  .sat_mode  (sat_mode),
  .op_a      (op_a),
  .op_b      (op_b),
  .out_valid (out_valid),
  .result    (result),
  .sat_flag  (sat_flag)
);

// File: tb/frac_mul_bench.sv
module frac_mul_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic        wide_mode;
  logic        sat_mode;
  logic [31:0] op_a;
  logic [31:0] op_b;
  logic        out_valid;
  logic [63:0] result;
  logic        sat_flag;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  frac_mul u_frac_mul (
    .clk(clk), .rst(rst), .in_valid(in_valid), .wide_mode(wide_mode),
    .sat_mode(sat_mode), .op_a(op_a), .op_b(op_b),
    .out_valid(out_valid), .result(result), .sat_flag(sat_flag)
  );

  function automatic void model(input logic [31:0] a, input logic [31:0] b,
                                input logic wide, input logic sat,
                                output logic [63:0] r, output logic f);
    logic signed [31:0] p32;
    logic signed [63:0] p64;
    if (!wide) begin
      p32 = $signed({{16{a[15]}}, a[15:0]}) * $signed({{16{b[15]}}, b[15:0]});
      if (sat && a[15:0] == 16'h8000 && b[15:0] == 16'h8000) begin
        r = 64'h0000_0000_7FFF_FFFF; f = 1'b1;
      end else begin
        r = {32'h0, p32[30:0], 1'b0}; f = p32[31] & p32[30];
      end
    end else begin
      p64 = $signed({{32{a[31]}}, a}) * $signed({{32{b[31]}}, b});
      if (sat && a == 32'h8000_0000 && b == 32'h8000_0000) begin
        r = 64'h7FFF_FFFF_FFFF_FFFF; f = 1'b1;
      end else begin
        r = {p64[62:0], 1'b0}; f = p64[63] & p64[62];
      end
    end
  endfunction

  task automatic check64(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drives one operation, checks the output the following cycle.
  task automatic run_op(input string req, input logic [31:0] a, input logic [31:0] b,
                        input logic wide, input logic sat);
    logic [63:0] er;
    logic        ef;
    model(a, b, wide, sat, er, ef);
    @(negedge clk);
    in_valid = 1'b1; wide_mode = wide; sat_mode = sat; op_a = a; op_b = b;
    @(negedge clk);
    in_valid = 1'b0; op_a = ~a; op_b = ~b;
    check64({req, " out_valid (R8)"}, {63'h0, out_valid}, 64'h1);
    check64({req, " result"}, result, er);
    check64({req, " flag (R3)"}, {63'h0, sat_flag}, {63'h0, ef});
  endtask

  task automatic test_reset();
    rst = 1'b1; in_valid = 1'b0; wide_mode = 1'b0; sat_mode = 1'b0;
    op_a = '0; op_b = '0;
    repeat (3) @(negedge clk);
    check64("R10 out_valid", {63'h0, out_valid}, 64'h0);
    check64("R10 result", result, 64'h0);
    check64("R10 flag", {63'h0, sat_flag}, 64'h0);
    rst = 1'b0;
  endtask

  task automatic test_narrow_mod();
    run_op("R1 half*half",  32'h0000_4000, 32'h0000_4000, 1'b0, 1'b0);
    run_op("R1 min*min wrap", 32'h0000_8000, 32'h0000_8000, 1'b0, 1'b0);
    run_op("R3 neg one*one",  32'h0000_FFFF, 32'h0000_0001, 1'b0, 1'b0);
    run_op("R1 mixed",  32'h0000_9ABC, 32'h0000_1234, 1'b0, 1'b0);
  endtask

  task automatic test_narrow_sat();
    run_op("R4 clamp", 32'h0000_8000, 32'h0000_8000, 1'b0, 1'b1);
    run_op("R6 single min", 32'h0000_8000, 32'h0000_7FFF, 1'b0, 1'b1);
    run_op("R6 neg flag", 32'h0000_FFFF, 32'h0000_0003, 1'b0, 1'b1);
  endtask

  task automatic test_narrow_upper();
    logic [63:0] ref_r;
    run_op("R7 clean", 32'h0000_4000, 32'h0000_C000, 1'b0, 1'b0);
    ref_r = result;
    run_op("R7 junk", 32'hABCD_4000, 32'h1357_C000, 1'b0, 1'b0);
    check64("R7 junk ignored", result, ref_r);
    run_op("R7 junk clamp", 32'hFFFF_8000, 32'h0001_8000, 1'b0, 1'b1);
  endtask

  task automatic test_wide();
    run_op("R2 min*min wrap", 32'h8000_0000, 32'h8000_0000, 1'b1, 1'b0);
    run_op("R2 neg*pos", 32'hFFFF_FFFD, 32'h0000_0005, 1'b1, 1'b0);
    run_op("R2 large", 32'h7FFF_FFFF, 32'h6000_0000, 1'b1, 1'b0);
    run_op("R5 clamp", 32'h8000_0000, 32'h8000_0000, 1'b1, 1'b1);
    run_op("R6 wide single min", 32'h8000_0000, 32'hFFFF_FFFF, 1'b1, 1'b1);
    run_op("R6 wide other", 32'h1234_5678, 32'h9ABC_DEF0, 1'b1, 1'b1);
  endtask

  task automatic test_hold();
    logic [63:0] r0;
    logic        f0;
    run_op("R9 setup", 32'hFFFF_FFFF, 32'h0000_0001, 1'b1, 1'b0);
    r0 = result; f0 = sat_flag;
    wide_mode = 1'b0; sat_mode = 1'b1; op_a = 32'h8000_8000; op_b = 32'h0000_8000;
    repeat (3) @(negedge clk);
    check64("R8 idle out_valid", {63'h0, out_valid}, 64'h0);
    check64("R9 result held", result, r0);
    check64("R9 flag held", {63'h0, sat_flag}, {63'h0, f0});
  endtask

  task automatic test_back_to_back();
    logic [63:0] e1, e2;
    logic        f1, f2;
    model(32'h0000_2000, 32'h0000_3000, 1'b0, 1'b0, e1, f1);
    model(32'h8000_0000, 32'h8000_0000, 1'b1, 1'b1, e2, f2);
    @(negedge clk);
    in_valid = 1'b1; wide_mode = 1'b0; sat_mode = 1'b0;
    op_a = 32'h0000_2000; op_b = 32'h0000_3000;
    @(negedge clk);
    check64("R8 b2b first valid", {63'h0, out_valid}, 64'h1);
    check64("R1 b2b first", result, e1);
    wide_mode = 1'b1; sat_mode = 1'b1; op_a = 32'h8000_0000; op_b = 32'h8000_0000;
    @(negedge clk);
    in_valid = 1'b0;
    check64("R8 b2b second valid", {63'h0, out_valid}, 64'h1);
    check64("R5 b2b second", result, e2);
    @(negedge clk);
    check64("R8 b2b drop", {63'h0, out_valid}, 64'h0);
  endtask

  task automatic test_reset_midrun();
    run_op("R10 pre", 32'h1111_1111, 32'h2222_2222, 1'b1, 1'b0);
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b1;
    @(negedge clk);
    rst = 1'b0; in_valid = 1'b0;
    check64("R10 mid result", result, 64'h0);
    check64("R10 mid valid", {63'h0, out_valid}, 64'h0);
  endtask

  initial begin
    test_reset();
    test_narrow_mod();
    test_narrow_sat();
    test_narrow_upper();
    test_wide();
    test_hold();
    test_back_to_back();
    test_reset_midrun();
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule